// File: doc/BRIEF.md
# Interrupt Priority Resolver with Promotable Maskable Source

The resolver takes every pending interrupt request in a small controller and names the single vector the CPU should service next. Four non-maskable sources (a reset request, an illegal-opcode trap, a software interrupt and an active-low external line that has its own mask) always outrank a bank of maskable sources. The maskable bank is made up of one external level-sensitive line, whose active level software picks, and `N_PERIPH` peripheral sources. Each peripheral source is gated by its own flag and its own local enable.

Two mask bits sit in the block. One global bit blocks all maskable sources. A second bit blocks only the external non-maskable line. Software can clear this second bit but can never set it again; only the CPU's acknowledge of a non-maskable vector sets it. A priority register lets software move any one maskable source to the top of the maskable order by writing that source's vector low byte. Both registers are reached through a byte-wide bus. The CPU reads `vec_o` while `req_o` is high, and pulses `ack_i` when it takes the vector.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the priority register (bus address 0) reads 0xF2 and the control register (bus address 1) reads 0x50. In the control register, bit 7 is the IRQ polarity, bit 6 is the X mask, bit 4 is the I mask, and all other bits read 0. `req_o` is 0 and `vec_o` is 0x00.
- R2: The non-maskable order is fixed and is not changed by the priority register: reset request 0xFE, then trap 0xF8, then software interrupt 0xF6, then external line 0xF4. Every one of them outranks every maskable source.
- R3: While X is 1, only the external non-maskable line (active low) is blocked. The reset request, trap and software interrupt are still served.
- R4: While I is 1, no maskable source is ever selected.
- R5: Peripheral source k is a candidate only when both its flag and its enable are 1.
- R6: The maskable IRQ pin is level-sensitive. With polarity bit 0 it is active low, and with polarity bit 1 it is active high.
- R7: With no promotion in effect, the IRQ pin (vector 0xF2) ranks first among the maskable sources, then peripheral k (vector 0xF0 − 2k) in rising k. The higher vector wins.
- R8: Writing the vector low byte of a maskable source to address 0 promotes that source above all other maskable sources. Written bit 0 is dropped and always reads back 0.
- R9: A write to address 0 whose value, with bit 0 cleared, is not a maskable vector is ignored, and the previous value is kept.
- R10: Writing 0 to control bit 6 clears X. Writing 1 there leaves X unchanged. Bits 7 and 4 are written directly.
- R11: When `ack_i` is high, I is set. If the vector on `vec_o` in that cycle is non-maskable (0xF4 or above), X is set as well. An acknowledge in the same cycle as a control write takes precedence over it.
- R12: `req_o`/`vec_o` are registered. They reflect the inputs and register values of the previous cycle. `vec_o` is 0x00 whenever `req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_src_i | input | 1 | Reset request source |
| trap_i | input | 1 | Illegal-opcode trap request |
| swi_i | input | 1 | Software interrupt request |
| xirq_n_i | input | 1 | External non-maskable line, active low |
| irq_pin_i | input | 1 | External maskable line, polarity set by control bit 7 |
| periph_flag_i | input | N_PERIPH | Peripheral event flags |
| periph_en_i | input | N_PERIPH | Peripheral local enables |
| ack_i | input | 1 | CPU takes the presented vector |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0: priority register, 1: control register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| req_o | output | 1 | Interrupt request to CPU |
| vec_o | output | 8 | Selected vector low byte |

## Verification
Any change to request inputs, masks or the priority register shows up on `req_o`/`vec_o` one clock edge later. Register writes and acknowledges change read data right after the edge that takes them, and they change the selection one edge after that. The bench drives inputs just after a falling edge. A behavioural model updates on the same rising edge as the design. On every falling edge, the model's request, vector and read data are compared with the outputs, so each result is checked in exactly the cycle it is due. Directed phases walk through each masking, ordering and promotion case in turn, and a random phase follows them.

// File: rtl/irq_prio_pkg.sv
// Shared constants for the interrupt priority resolver.
// Assumes 8-bit vector low bytes, with maskable vectors descending from 0xF2.
package irq_prio_pkg;
    localparam logic [7:0] VEC_RST  = 8'hFE;
    localparam logic [7:0] VEC_TRAP = 8'hF8;
    localparam logic [7:0] VEC_SWI  = 8'hF6;
    localparam logic [7:0] VEC_XIRQ = 8'hF4;
    localparam logic [7:0] VEC_IRQ  = 8'hF2;
    localparam logic [7:0] CTRL_RST = 8'h50;
    localparam int         POL_BIT  = 7;
    localparam int         X_BIT    = 6;
    localparam int         I_BIT    = 4;
endpackage

// File: rtl/irq_prio_regs.sv
// Priority and control registers with the byte bus.
// Assumes maskable index j maps to vector 0xF2 - 2j, for j = 0..N_PERIPH.
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int N_PERIPH = 8,
    localparam int NM = N_PERIPH + 1,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          addr_i,
    input  logic [7:0]    wdata_i,
    input  logic          ack_i,
    input  logic          ack_nmi_i,
    output logic [7:0]    rdata_o,
    output logic          x_o,
    output logic          i_o,
    output logic          pol_o,
    output logic [IW-1:0] promo_idx_o
);
    localparam logic [7:0] VEC_LOW = 8'(int'(VEC_IRQ) - 2 * N_PERIPH);

    logic [7:0] hp_q;
    logic       x_q, i_q, pol_q;
    logic [7:0] wr_vec;
    logic       wr_ok;

    // Check a priority write against the maskable vector range
    always_comb begin
        wr_vec = {wdata_i[7:1], 1'b0};
        wr_ok  = (wr_vec <= VEC_IRQ) && (wr_vec >= VEC_LOW);
    end

    // Priority register: only valid maskable vectors are stored
    always_ff @(posedge clk) begin
        if (!rst_n)                        hp_q <= VEC_IRQ;
        else if (we_i && !addr_i && wr_ok) hp_q <= wr_vec;
    end

    // Control bits: acknowledge sets masks, X can only be cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= 1'b1;
            i_q   <= 1'b1;
            pol_q <= 1'b0;
        end else begin
            if (we_i && addr_i) begin
                pol_q <= wdata_i[POL_BIT];
                i_q   <= wdata_i[I_BIT];
                if (!wdata_i[X_BIT]) x_q <= 1'b0;
            end
            if (ack_i)     i_q <= 1'b1;
            if (ack_nmi_i) x_q <= 1'b1;
        end
    end

    // Read mux and derived promoted index
    always_comb begin
        rdata_o     = addr_i ? {pol_q, x_q, 1'b0, i_q, 4'b0000} : hp_q;
        promo_idx_o = IW'((VEC_IRQ - hp_q) >> 1);
        x_o         = x_q;
        i_o         = i_q;
        pol_o       = pol_q;
    end

    // R10
    x_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q && !$past(x_q)) |-> $past(ack_nmi_i));
    // R11
    i_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_i) |-> i_q);
    // R9
    hp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_q != $past(hp_q)) |-> $past(we_i && !addr_i));
endmodule

// File: rtl/irq_prio_arb.sv
// Maskable arbiter: fixed order by index (lowest wins) with one promoted index.
// Assumes promo_idx_i < NM. Purely combinational.
module irq_prio_arb #(
    parameter int N_PERIPH = 8,
    localparam int NM = N_PERIPH + 1,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic [NM-1:0] elig_i,
    input  logic [IW-1:0] promo_idx_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    logic          def_valid;
    logic [IW-1:0] def_idx;

    // Fixed order scan: the lowest set index wins
    always_comb begin
        def_valid = 1'b0;
        def_idx   = '0;
        for (int j = NM - 1; j >= 0; j--) begin
            if (elig_i[j]) begin
                def_valid = 1'b1;
                def_idx   = IW'(j);
            end
        end
    end

    // Promoted source overrides the fixed order when it is a candidate
    always_comb begin
        valid_o = def_valid;
        idx_o   = elig_i[promo_idx_i] ? promo_idx_i : def_idx;
    end
endmodule

// File: rtl/irq_prio_resolver.sv
// Top: ranks non-maskable sources over the masked maskable arbiter result and
// registers the request and vector. Assumes ack_i is only used while req_o is high.
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int N_PERIPH = 8,
    localparam int NM = N_PERIPH + 1,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_src_i,
    input  logic                trap_i,
    input  logic                swi_i,
    input  logic                xirq_n_i,
    input  logic                irq_pin_i,
    input  logic [N_PERIPH-1:0] periph_flag_i,
    input  logic [N_PERIPH-1:0] periph_en_i,
    input  logic                ack_i,
    input  logic                bus_we_i,
    input  logic                bus_addr_i,
    input  logic [7:0]          bus_wdata_i,
    output logic [7:0]          bus_rdata_o,
    output logic                req_o,
    output logic [7:0]          vec_o
);
    logic          x_m, i_m, pol;
    logic [IW-1:0] promo_idx;
    logic [NM-1:0] elig;
    logic          arb_valid;
    logic [IW-1:0] arb_idx;
    logic          sel_valid, ack_nmi;
    logic [7:0]    sel_vec;
    logic          req_q;
    logic [7:0]    vec_q;

    irq_prio_regs #(.N_PERIPH(N_PERIPH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .ack_i(ack_i), .ack_nmi_i(ack_nmi),
        .rdata_o(bus_rdata_o), .x_o(x_m), .i_o(i_m), .pol_o(pol),
        .promo_idx_o(promo_idx)
    );

    // Candidate vector: IRQ pin at index 0, peripherals above, all gated by I
    always_comb begin
        elig = {periph_flag_i & periph_en_i, (irq_pin_i == pol)} & {NM{!i_m}};
    end

    irq_prio_arb #(.N_PERIPH(N_PERIPH)) u_arb (
        .elig_i(elig), .promo_idx_i(promo_idx),
        .valid_o(arb_valid), .idx_o(arb_idx)
    );

    // Fixed non-maskable chain ahead of the maskable result
    always_comb begin
        sel_valid = 1'b1;
        if (rst_src_i)               sel_vec = VEC_RST;
        else if (trap_i)             sel_vec = VEC_TRAP;
        else if (swi_i)              sel_vec = VEC_SWI;
        else if (!xirq_n_i && !x_m)  sel_vec = VEC_XIRQ;
        else if (arb_valid)          sel_vec = VEC_IRQ - 8'({arb_idx, 1'b0});
        else begin
            sel_valid = 1'b0;
            sel_vec   = 8'h00;
        end
        ack_nmi = ack_i && req_q && (vec_q >= VEC_XIRQ);
    end

    // Output register for the CPU request and vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            vec_q <= 8'h00;
        end else begin
            req_q <= sel_valid;
            vec_q <= sel_vec;
        end
    end

    assign req_o = req_q;
    assign vec_o = vec_q;

    // R4
    maskable_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && vec_q <= VEC_IRQ) |-> $past(!i_m));
    // R3
    xirq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_q == VEC_XIRQ) |-> $past(!x_m && !rst_src_i && !trap_i && !swi_i));
    // R2
    nmi_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_src_i || trap_i || swi_i) |-> (req_q && vec_q >= VEC_SWI));
    // R5
    arb_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> elig[arb_idx]);
    // R12
    idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q |-> (vec_q == 8'h00));
endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_src = 0, trap = 0, swi = 0, xirq_n = 1, irq_pin = 1, ack = 0;
    logic [N-1:0] flag = '0, en = '0;
    logic we = 0, addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata, vec;
    logic req;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // behavioural model state
    int m_hp, m_x, m_i, m_pol, m_req, m_vec;

    always #4 clk = ~clk;

    irq_prio_resolver #(.N_PERIPH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_src_i(rst_src), .trap_i(trap), .swi_i(swi),
        .xirq_n_i(xirq_n), .irq_pin_i(irq_pin), .periph_flag_i(flag),
        .periph_en_i(en), .ack_i(ack), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .req_o(req), .vec_o(vec)
    );

    function automatic bit cand(int j);
        if (j == 0) return (irq_pin == m_pol[0]);
        return flag[j-1] && en[j-1];
    endfunction

    // reference model, one update per rising edge
    always @(posedge clk) begin
        int v, p, w;
        if (!rst_n) begin
            m_hp = 'hF2; m_x = 1; m_i = 1; m_pol = 0; m_req = 0; m_vec = 0;
        end else begin
            v = 0;
            if (rst_src) v = 'hFE;
            else if (trap) v = 'hF8;
            else if (swi) v = 'hF6;
            else if (!xirq_n && m_x == 0) v = 'hF4;
            else if (m_i == 0) begin
                p = ('hF2 - m_hp) / 2;
                if (cand(p)) v = m_hp;
                else for (int j = N; j >= 0; j--) if (cand(j)) v = 'hF2 - 2 * j;
            end
            if (we && !addr) begin
                w = int'(wdata) & 'hFE;
                if (w <= 'hF2 && w >= 'hF2 - 2 * N) m_hp = w;
            end
            if (we && addr) begin
                m_pol = wdata[7]; m_i = wdata[4];
                if (!wdata[6]) m_x = 0;
            end
            if (ack) begin
                m_i = 1;
                if (m_req != 0 && m_vec >= 'hF4) m_x = 1;
            end
            m_vec = v; m_req = (v != 0);
        end
    end

    function automatic int model_rd();
        if (addr) return m_pol * 128 + m_x * 64 + m_i * 16;
        return m_hp;
    endfunction

    // advance one cycle and compare all outputs away from the rising edge
    task automatic step(input string tag);
        @(negedge clk);
        n_chk++;
        if (req !== m_req[0] || int'(vec) != m_vec || int'(rdata) != model_rd()) begin
            n_fail++;
            $display("FAIL %s: req=%0d vec=%02h rdata=%02h expected req=%0d vec=%02h rdata=%02h",
                     tag, req, vec, rdata, m_req, m_vec, model_rd());
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d, input string tag);
        we = 1; addr = a; wdata = d; step(tag); we = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1; n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        addr = 0; step("R1 prio reset");
        addr = 1; step("R1 ctrl reset");
        // non-maskable under X=I=1
        xirq_n = 0; step("R3 xirq blocked"); step("R3 xirq blocked");
        trap = 1; step("R3 trap served"); step("R3 trap served");
        swi = 1; step("R2 trap over swi");
        trap = 0; step("R2 swi"); step("R2 swi");
        rst_src = 1; step("R2 reset first"); step("R2 reset first");
        rst_src = 0; swi = 0; xirq_n = 1;
        flag = 8'hFF; en = 8'hFF; irq_pin = 0; step("R4 I set"); step("R4 I set");
        flag = 0; en = 0; irq_pin = 1;
        wr(1, 8'h00, "R10 clear masks"); step("R10 clear masks");
        wr(1, 8'h40, "R10 X stays clear"); step("R10 X stays clear");
        xirq_n = 0; flag = 8'h01; en = 8'h01; step("R2 xirq over maskable"); step("R2 xirq over maskable");
        xirq_n = 1; flag = 8'h04; en = 8'h00; step("R5 no enable"); step("R5 no enable");
        en = 8'h04; step("R7 periph2"); step("R7 periph2");
        flag = 8'h84; en = 8'hFF; step("R7 lower k wins"); step("R7 lower k wins");
        irq_pin = 0; step("R6 active low"); step("R7 irq top");
        wr(1, 8'h80, "R6 polarity high"); step("R6 pin low ignored"); step("R6 pin low ignored");
        irq_pin = 1; step("R6 active high"); step("R6 active high");
        irq_pin = 0;
        flag = 8'h22; wr(0, 8'hE6, "R8 promote p5"); step("R8 promoted"); step("R8 promoted");
        wr(0, 8'hE7, "R8 bit0 dropped"); step("R8 bit0 dropped");
        flag = 8'h02; step("R8 fallback"); step("R8 fallback");
        wr(0, 8'h40, "R9 out of range"); step("R9 kept");
        wr(0, 8'hF4, "R9 nmi vector"); step("R9 kept");
        wr(0, 8'hE0, "R9 below range"); step("R9 kept");
        ack = 1; step("R11 ack maskable"); ack = 0;
        step("R11 I set"); step("R11 I set");
        wr(1, 8'h00, "R11 clear I");
        xirq_n = 0; step("R11 xirq"); step("R11 xirq");
        ack = 1; step("R11 ack nmi"); ack = 0;
        addr = 1; step("R11 X set"); step("R11 X set");
        // random phase
        for (int k = 0; k < 600; k++) begin
            rst_src = ($urandom % 40) == 0; trap = ($urandom % 20) == 0;
            swi = ($urandom % 20) == 0; xirq_n = ($urandom % 4) != 0;
            irq_pin = $urandom; flag = N'($urandom); en = N'($urandom);
            we = ($urandom % 6) == 0; addr = $urandom;
            wdata = ($urandom % 2) ? 8'($urandom) : 8'(8'hE2 + 2 * ($urandom % 9));
            if (addr && ($urandom % 2)) wdata[4] = 0;
            ack = m_req != 0 && ($urandom % 3) == 0;
            step("R12 random");
        end
        we = 0; ack = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule